// File: doc/BRIEF.md
# Serial Word Deserializer with Word Clock Generator

This block rebuilds parallel words from a single-wire serial stream. The stream arrives one bit per cycle of a bit-valid enable. Between words the line idles at zero. A one seen on an idle line marks the start of a word, and the next 24 enabled bits are the payload. The first 22 payload bits go to a data bus that an output enable can release. The last two payload bits go to a pair of dedicated outputs that are never disabled.

Alongside the data the block produces a word clock, which makes one cycle per received word. The clock falls on the cycle the new word lands on the outputs. It stays low for exactly 13 bit times and then returns high. It then stays high for however many idle bits the sender inserts, so its duty cycle follows the ratio between the sender's reference and its word rate. A two-bit mode input selects power-down or one of three active rate settings. A direction input turns the receive side on and off. Downstream logic captures the outputs on the rising edge of the word clock, or on any point of its low phase.

Top module: `word_deser`

## Requirements
- R1: While the framer is idle, enabled zero bits are ignored. An enabled one is a start marker, and exactly the next 24 enabled bits form the payload. The framer then returns to idle, and an enabled bit received in the same cycle as the last payload bit cannot start a new word.
- R2: Payload bit k, counted from 0 as the first bit after the marker, appears on `dataOut[k]` for k from 0 to 21. Bit 22 appears on `dedOut[0]` and bit 23 on `dedOut[1]`.
- R3: All 24 outputs take their new values at the clock edge that samples the last payload bit. The outputs change at no other edge except for a power-down clear.
- R4: `wordClk` falls at that same edge, so it falls exactly once per received word. It stays low until the edge that samples the 13th enabled bit after the fall, where it rises. Otherwise it stays high.
- R5: `mode` codes: 00 is power-down, and 01, 10 and 11 are active. Framing, field mapping and word clock timing are the same in all three active codes.
- R6: In power-down (mode 00), and under reset, the framer is cleared and any partial word is discarded. From the next edge on, `dataOut` and `dedOut` read zero and `wordClk` is high. `dataOut` and `dedOut` therefore read zero after power-up until the first complete word.
- R7: With `dirDes` low, the serial input is ignored and the framer is cleared. From the next edge on, `wordClk` is held high. `dataOut` and `dedOut` keep their last values.
- R8: `dataOe` is high exactly when `mode` is not 00 and `dirDes` is high. It follows those inputs without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial data bit, sampled when bitEn is high |
| bitEn | input | 1 | Bit-valid enable; one bit time per high cycle |
| mode | input | 2 | 00 power-down, 01/10/11 active rate settings |
| dirDes | input | 1 | 1 = receive (deserializer) direction, 0 = transmit direction |
| dataOut | output | 22 | Reassembled data bits |
| dedOut | output | 2 | Dedicated outputs, carrying payload bits 22 and 23 |
| dataOe | output | 1 | Enable for the data bus drivers |
| wordClk | output | 1 | Word clock: low for 13 bit times from each word update |

## Verification
The assertions assume that the sender leaves at least 13 bit times between the last payload bit of one word and the last bit of the next. A whole word already takes 25 enabled bits, so no new word can land during a word clock low phase. They also assume that mode and direction are not changed while the word clock is low. The stimulus follows both rules. Every word is followed by 14 or more idle zero bits before mode or direction is touched, and back-to-back words with no idle gap are still 25 bits apart.

// File: rtl/word_deser_pkg.sv
package word_deser_pkg;

  // strobes from the framing control to the word datapath
  typedef struct packed {
    logic shift;   // accept one payload bit
    logic load;    // final payload bit: publish the word
    logic clear;   // power-down: zero the published word
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_PAYLOAD = 1'b1
  } frameSt_t;

  localparam logic [1:0] MODE_OFF = 2'b00;

endpackage

// File: rtl/word_deser_ctrl.sv
module word_deser_ctrl
  import word_deser_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int LOW_BITS  = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIn,
  input  logic       bitEn,
  input  logic [1:0] mode,
  input  logic       dirDes,
  output dpStrobe_t  strobe,
  output logic       dataOe,
  output logic       wordClk
);

  localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int LOW_W = (LOW_BITS > 1) ? $clog2(LOW_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(LOW_BITS - 1);

  frameSt_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic [LOW_W-1:0] lowCnt;
  logic             active;
  logic             lastBit;

  always_comb begin
    active       = (mode != MODE_OFF) && dirDes;
    lastBit      = (bitCnt == LAST_IDX);
    strobe.shift = active && bitEn && (state == ST_PAYLOAD);
    strobe.load  = strobe.shift && lastBit;
    strobe.clear = (mode == MODE_OFF);
    dataOe       = active;
  end

  // framing: idle hunts for the marker, payload counts bits
  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (bitEn) begin
      unique case (state)
        ST_IDLE: begin
          if (serIn) begin
            state  <= ST_PAYLOAD;
            bitCnt <= '0;
          end
        end
        ST_PAYLOAD: begin
          if (lastBit) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // word clock: falls on publish, high again after LOW_BITS enables
  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      wordClk <= 1'b1;
      lowCnt  <= '0;
    end else if (strobe.load) begin
      wordClk <= 1'b0;
      lowCnt  <= '0;
    end else if (!wordClk && bitEn) begin
      if (lowCnt == LOW_LAST) begin
        wordClk <= 1'b1;
        lowCnt  <= '0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/word_deser_dp.sv
module word_deser_dp
  import word_deser_pkg::*;
#(
  parameter int DATA_BITS = 22,
  parameter int DED_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  dpStrobe_t            strobe,
  output logic [DATA_BITS-1:0] dataOut,
  output logic [DED_BITS-1:0]  dedOut
);

  localparam int WORD_BITS = DATA_BITS + DED_BITS;

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] assembled;
  logic [WORD_BITS-1:0] outWord;

  // first bit received ends up in bit 0
  always_comb assembled = {serIn, shiftReg[WORD_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= assembled;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      outWord <= '0;
    end else if (strobe.load) begin
      outWord <= assembled;
    end
  end

  always_comb begin
    dataOut = outWord[DATA_BITS-1:0];
    dedOut  = outWord[WORD_BITS-1:DATA_BITS];
  end

endmodule

// File: rtl/word_deser.sv
module word_deser
  import word_deser_pkg::*;
#(
  parameter int DATA_BITS = 22,
  parameter int DED_BITS  = 2,
  parameter int LOW_BITS  = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 bitEn,
  input  logic [1:0]           mode,
  input  logic                 dirDes,
  output logic [DATA_BITS-1:0] dataOut,
  output logic [DED_BITS-1:0]  dedOut,
  output logic                 dataOe,
  output logic                 wordClk
);

  localparam int WORD_BITS = DATA_BITS + DED_BITS;

  dpStrobe_t strobe;

  word_deser_ctrl #(
    .WORD_BITS(WORD_BITS),
    .LOW_BITS (LOW_BITS)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .serIn  (serIn),
    .bitEn  (bitEn),
    .mode   (mode),
    .dirDes (dirDes),
    .strobe (strobe),
    .dataOe (dataOe),
    .wordClk(wordClk)
  );

  word_deser_dp #(
    .DATA_BITS(DATA_BITS),
    .DED_BITS (DED_BITS)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .serIn  (serIn),
    .strobe (strobe),
    .dataOut(dataOut),
    .dedOut (dedOut)
  );

endmodule

// File: rtl/word_deser_chk.sv
module word_deser_chk #(
  parameter int DATA_BITS = 22,
  parameter int DED_BITS  = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bitEn,
  input logic [1:0]           mode,
  input logic                 dirDes,
  input logic [DATA_BITS-1:0] dataOut,
  input logic [DED_BITS-1:0]  dedOut,
  input logic                 wordClk
);

  // R7 / R6: receive side off forces the word clock high on the next edge
  a_r7_wordclk_high_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !((mode != 2'b00) && dirDes) |=> wordClk);

  // R6: power-down zeroes every output on the next edge
  a_r6_powerdown_clears: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |=> (dataOut == '0) && (dedOut == '0));

  // R3: in an active mode, outputs only change together with a word clock fall
  a_r3_update_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable({dedOut, dataOut}) && ($past(mode) != 2'b00)) |-> $fell(wordClk));

  // R4: the word clock only rises on a bit enable while receiving
  a_r4_rise_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wordClk) && $past((mode != 2'b00) && dirDes)) |-> $past(bitEn));

endmodule

bind word_deser word_deser_chk #(
  .DATA_BITS(DATA_BITS),
  .DED_BITS (DED_BITS)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .bitEn  (bitEn),
  .mode   (mode),
  .dirDes (dirDes),
  .dataOut(dataOut),
  .dedOut (dedOut),
  .wordClk(wordClk)
);

// File: tb/word_deser_test.sv
module word_deser_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0;
  logic        bitEn = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        dirDes = 1'b1;
  logic [21:0] dataOut;
  logic [1:0]  dedOut;
  logic        dataOe;
  logic        wordClk;

  int nChecks = 0;
  int nFails = 0;
  int spc = 1;            // cycles per bit time
  logic [23:0] expQ[$];
  logic [23:0] lastWord = '0;
  logic prevWc = 1'b1;
  int lowCnt = 0;
  bit inLow = 1'b0;

  always #10 clk = ~clk;

  word_deser uut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .bitEn(bitEn), .mode(mode),
    .dirDes(dirDes), .dataOut(dataOut), .dedOut(dedOut), .dataOe(dataOe),
    .wordClk(wordClk)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    for (int i = 1; i < spc; i++) begin
      @(posedge clk); #2;
      bitEn = 1'b0; serIn = 1'b0;
    end
    @(posedge clk); #2;
    bitEn = 1'b1; serIn = b;
  endtask

  task automatic flush();
    @(posedge clk); #2;
    bitEn = 1'b0; serIn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  // driver: pushes the expected item, then drives marker + payload (R1, R2)
  task automatic sendWord(input logic [23:0] w);
    expQ.push_back(w);
    lastWord = w;
    sendBit(1'b1);
    for (int k = 0; k < 24; k++) sendBit(w[k]);
  endtask

  // partial word: marker plus n payload bits
  task automatic sendPartial(input logic [23:0] w, input int n);
    sendBit(1'b1);
    for (int k = 0; k < n; k++) sendBit(w[k]);
  endtask

  // monitor: pop on each word clock fall, measure the low phase
  always @(negedge clk) begin
    if (rstN) begin
      if (prevWc && !wordClk) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected word clock fall", {8'h0, dedOut, dataOut}, 32'h0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check(dataOut == e[21:0], "R2 data field", {10'h0, dataOut}, {10'h0, e[21:0]});
          check(dedOut == e[23:22], "R2 dedicated field", {30'h0, dedOut}, {30'h0, e[23:22]});
        end
        lowCnt = 0;
        inLow = 1'b1;
      end else if (!prevWc && wordClk && inLow) begin
        check(lowCnt == 13, "R4 low phase length", lowCnt, 13);
        inLow = 1'b0;
      end
      if (!wordClk && bitEn) lowCnt++;
      prevWc = wordClk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R6: power-up state
    check(dataOut == '0, "R6 reset data", {10'h0, dataOut}, 0);
    check(dedOut == '0, "R6 reset dedicated", {30'h0, dedOut}, 0);
    check(wordClk == 1'b1, "R6 reset word clock", {31'h0, wordClk}, 1);
    check(dataOe == 1'b1, "R8 enable active", {31'h0, dataOe}, 1);

    // R1/R5: mode 01, one bit per cycle, gaps of varying idle fill
    spc = 1;
    idle(3);
    sendWord(24'hA5_3C_96);
    idle(14);
    sendWord(24'h80_0001);
    idle(20);
    // back-to-back words, no idle between them
    sendWord(24'hFF_FFFF);
    sendWord(24'h40_0000);
    idle(14);
    sendWord(24'h00_0000);
    idle(14);
    flush();
    repeat (4) @(negedge clk);
    // R3: outputs hold steady during idle fill
    check({dedOut, dataOut} == lastWord, "R3 hold after word", {8'h0, dedOut, dataOut}, {8'h0, lastWord});

    // R5: mode 10, bit every 2 cycles
    mode = 2'b10; spc = 2;
    idle(5);
    sendWord(24'h12_3457);
    idle(14);
    // R5: mode 11, bit every 3 cycles
    mode = 2'b11; spc = 3;
    idle(4);
    sendWord(24'hC0_FFEE);
    idle(16);
    flush();
    repeat (3) @(negedge clk);

    // R7: transmit direction
    dirDes = 1'b0;
    @(negedge clk);
    check(dataOe == 1'b0, "R8 enable off in transmit", {31'h0, dataOe}, 0);
    spc = 1;
    idle(2);
    sendPartial(24'h55_5555, 24);
    idle(3);
    flush();
    repeat (3) @(negedge clk);
    check(wordClk == 1'b1, "R7 word clock high", {31'h0, wordClk}, 1);
    check({dedOut, dataOut} == lastWord, "R7 outputs keep values", {8'h0, dedOut, dataOut}, {8'h0, lastWord});
    dirDes = 1'b1;
    @(negedge clk);
    check(dataOe == 1'b1, "R8 enable back on", {31'h0, dataOe}, 1);

    // R7: partial word discarded by direction change
    idle(2);
    sendPartial(24'hFF_FFFF, 10);
    flush();
    dirDes = 1'b0;
    repeat (2) @(negedge clk);
    dirDes = 1'b1;
    sendWord(24'h0F_0F0F);
    idle(14);
    flush();

    // R6: power-down mid-word clears outputs and the partial
    idle(2);
    sendPartial(24'hFF_FFFF, 12);
    flush();
    mode = 2'b00;
    repeat (2) @(negedge clk);
    check(dataOut == '0, "R6 power-down data", {10'h0, dataOut}, 0);
    check(dedOut == '0, "R6 power-down dedicated", {30'h0, dedOut}, 0);
    check(wordClk == 1'b1, "R6 power-down word clock", {31'h0, wordClk}, 1);
    check(dataOe == 1'b0, "R8 enable off in power-down", {31'h0, dataOe}, 0);
    mode = 2'b01;
    sendWord(24'h3A_5A5A);
    idle(14);
    flush();
    repeat (4) @(negedge clk);

    check(expQ.size() == 0, "R4 one fall per word", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule